// File: doc/BRIEF.md
# Real-Time Clock Register Core

This block is a real-time clock reached over a plain 32-bit register bus. A 32-bit seconds count advances once every `TICKS_PER_SEC` pulses of a slow-clock enable (32768 by default, a 32.768 kHz enable). The count runs only while the run bit in the control register is set. A seconds-alarm register, a control/status register and a free 32-bit scratch word sit beside it. The scratch word lets software keep a marker that says the stored time is valid.

Writes are guarded in two ways. A write lands only while the ready bit reads high. After a write is taken, ready stays low for `WR_BUSY_CYCLES` cycles. When `UNLOCK_REQUIRED` is set, software must also first store a key into the unlock register. The key admits exactly one further write. The tick flag and the alarm flag are sticky. Writing 0 to a flag clears it and writing 1 leaves it alone, so a read-modify-write of the control register never drops a pending event. The single interrupt output combines each flag with its own enable.

Top module: `rtc_regfile`

## Requirements
- R1: After reset the control register reads 0x00000080 (only ready set). Seconds, alarm, scratch and unlock all read 0, and `irq` is low.
- R2: A read pulse on `rd_en` returns the register at `addr` on `rdata` from the next clock edge. The offsets are 0x00 control, 0x04 seconds, 0x08 alarm, 0x34 scratch and 0x3C unlock. Any other offset reads 0.
- R3: A write presented while the ready bit (control bit 7) is low is ignored.
- R4: Writing 0x0000A55A to offset 0x3C sets unlock bit 31, and any other value leaves it clear. While bit 31 is clear, writes to the other offsets are ignored. Bit 31 clears after one accepted write to another offset.
- R5: After an accepted write, the ready bit reads 0 for `WR_BUSY_CYCLES` cycles and then reads 1 again. A write ignored because of the lock does not lower ready.
- R6: While control bit 0 (run) is 1, the seconds count rises by one for every `TICKS_PER_SEC` enable pulses, wrapping from 0xFFFFFFFF to 0. While run is 0 it holds.
- R7: Every advance of the seconds count sets the tick flag, control bit 6.
- R8: Writing 0 to control bit 6 or bit 4 clears that flag, and writing 1 keeps it. If a flag's set event falls in the same cycle as a write that clears it, the flag ends set.
- R9: With alarm enable (control bit 2) at 1, the alarm flag (control bit 4) is set when the seconds count becomes equal to the alarm register.
- R10: `irq` is high exactly when (bit 4 and bit 3) or (bit 6 and bit 5) of the control register are both 1.
- R11: The scratch register stores any 32-bit value written to it.
- R12: Control bits 5, 3, 2 and 0 are plain read/write. Bit 7 ignores writes, and bits 31:8 and bit 1 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | One-cycle pulse per slow-oscillator period |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| irq | output | 1 | Interrupt request |

## Verification
The tick flag can be set by a seconds advance in the same cycle that a control write clears it. The bench lines up the prescaler one pulse short of a second and unlocks the block. It then presents the enable pulse and a control write with bit 6 at 0 on the same clock edge. A read of the control register must then show bit 6 set, with the seconds count one higher. A second clearing write, made with no tick nearby, must then read back the flag as 0.

// File: rtl/rtc_regfile.sv
module rtc_regfile #(
  parameter int TICKS_PER_SEC   = 32768,
  parameter int WR_BUSY_CYCLES  = 4,
  parameter bit UNLOCK_REQUIRED = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_en,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [7:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq
);
  localparam int PW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam int BW = $clog2(WR_BUSY_CYCLES + 1);
  localparam logic [7:0] A_CTRL = 8'h00, A_SEC = 8'h04, A_ALM = 8'h08,
                         A_SCR = 8'h34, A_KEY = 8'h3C;
  localparam logic [31:0] KEY = 32'h0000_A55A;

  logic [PW-1:0] pre;
  logic [BW-1:0] busy;
  logic [31:0]   sec, alm, scr;
  logic          run, alm_en, alm_ie, sec_ie, alm_f, sec_f, match_q;
  logic          unlocked, ready, wr_ok, sec_tick, match, alm_hit;

  assign ready    = (busy == '0);
  assign wr_ok    = wr_en && ready && (unlocked || addr == A_KEY);
  assign sec_tick = run && tick_en && (pre == PW'(TICKS_PER_SEC - 1));
  assign match    = (sec == alm);
  assign alm_hit  = alm_en && match && !match_q;
  assign irq      = (alm_f && alm_ie) || (sec_f && sec_ie);

  generate
    if (UNLOCK_REQUIRED) begin : g_lock
      logic key_q;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) key_q <= 1'b0;
        else if (wr_ok) key_q <= (addr == A_KEY) ? (wdata == KEY) : 1'b0;
      assign unlocked = key_q;
    end else begin : g_open
      assign unlocked = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) busy <= '0;
    else if (wr_ok) busy <= BW'(WR_BUSY_CYCLES);
    else if (!ready) busy <= busy - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pre <= '0;
    else if (run && tick_en) pre <= (pre == PW'(TICKS_PER_SEC - 1)) ? '0 : pre + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sec <= '0;
    else if (wr_ok && addr == A_SEC) sec <= wdata;
    else if (sec_tick) sec <= sec + 32'd1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      alm <= '0;
      scr <= '0;
    end else if (wr_ok) begin
      if (addr == A_ALM) alm <= wdata;
      if (addr == A_SCR) scr <= wdata;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {run, alm_en, alm_ie, sec_ie} <= '0;
      {alm_f, sec_f, match_q} <= '0;
    end else begin
      match_q <= match;
      if (wr_ok && addr == A_CTRL) begin
        run    <= wdata[0];
        alm_en <= wdata[2];
        alm_ie <= wdata[3];
        sec_ie <= wdata[5];
      end
      if (sec_tick) sec_f <= 1'b1;
      else if (wr_ok && addr == A_CTRL && !wdata[6]) sec_f <= 1'b0;
      if (alm_hit) alm_f <= 1'b1;
      else if (wr_ok && addr == A_CTRL && !wdata[4]) alm_f <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rdata <= '0;
    else if (rd_en)
      case (addr)
        A_CTRL:  rdata <= {24'd0, ready, sec_f, sec_ie, alm_f, alm_ie, alm_en, 1'b0, run};
        A_SEC:   rdata <= sec;
        A_ALM:   rdata <= alm;
        A_SCR:   rdata <= scr;
        A_KEY:   rdata <= {unlocked && UNLOCK_REQUIRED, 31'd0};
        default: rdata <= '0;
      endcase

  // R5: an accepted write lowers ready on the next cycle
  p_ready_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> !ready);

  // R4: unlock is spent by one accepted write elsewhere
  p_lock_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && addr != A_KEY && UNLOCK_REQUIRED) |=> !unlocked);

  // R4: locked writes leave the scratch word alone
  p_locked_ignore_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !unlocked && addr == A_SCR) |=> $stable(scr));

  // R6: seconds hold while the run bit is low
  p_sec_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !(wr_ok && addr == A_SEC)) |=> $stable(sec));

  // R8: a tick flag is only lost through a control write
  p_sec_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_f && !(wr_ok && addr == A_CTRL)) |=> sec_f);
endmodule

// File: tb/rtc_regfile_tb_top.sv
module rtc_regfile_tb_top;
  localparam int TPS = 4;
  localparam int BUSY = 3;

  logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq;
  int errors = 0, checks = 0;
  logic rd_fire = 1'b0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  rtc_regfile #(.TICKS_PER_SEC(TPS), .WR_BUSY_CYCLES(BUSY), .UNLOCK_REQUIRED(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  always @(posedge clk) rd_fire <= rd_en;

  always @(negedge clk)
    if (rd_fire && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        errors++;
        $display("FAIL %s: rdata=%h expected=%h", t, rdata, e);
      end
    end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] e, string t);
    @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(t);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, logic with_tick = 1'b0);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d; tick_en = with_tick;
    @(negedge clk);
    wr_en = 1'b0; tick_en = 1'b0;
  endtask

  task automatic uwr(logic [7:0] a, logic [31:0] d, logic with_tick = 1'b0);
    wr(8'h3C, 32'h0000_A55A);
    idle(BUSY + 1);
    wr(a, d, with_tick);
    idle(BUSY + 1);
  endtask

  task automatic pulse(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_en = 1'b1;
      @(negedge clk) tick_en = 1'b0;
    end
    idle(2);
  endtask

  task automatic chk_irq(logic e, string t);
    @(negedge clk);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s: irq=%b expected=%b", t, irq, e);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    // R1 reset state, R2 read path
    rd(8'h00, 32'h80, "R1 ctrl");
    rd(8'h04, 0, "R1 sec");
    rd(8'h08, 0, "R1 alarm");
    rd(8'h34, 0, "R1 scratch");
    rd(8'h3C, 0, "R1 unlock");
    chk_irq(1'b0, "R1 irq");
    rd(8'h10, 0, "R2 unmapped");
    // R4 locked write ignored, no busy (R5)
    wr(8'h34, 32'hDEAD);
    rd(8'h00, 32'h80, "R5 locked write keeps ready");
    rd(8'h34, 0, "R4 locked write ignored");
    // R4 wrong key
    wr(8'h3C, 32'h1234);
    idle(BUSY + 1);
    rd(8'h3C, 0, "R4 wrong key");
    // R4 right key
    wr(8'h3C, 32'h0000_A55A);
    idle(BUSY + 1);
    rd(8'h3C, 32'h8000_0000, "R4 key sets bit31");
    wr(8'h34, 32'h1234_5678);
    rd(8'h00, 32'h00, "R5 ready low after write");
    idle(BUSY);
    rd(8'h00, 32'h80, "R5 ready back");
    rd(8'h34, 32'h1234_5678, "R11 scratch");
    rd(8'h3C, 0, "R4 unlock spent");
    // R3 write during busy ignored
    wr(8'h3C, 32'h0000_A55A);
    wr(8'h34, 32'h0BAD);
    idle(BUSY + 1);
    rd(8'h34, 32'h1234_5678, "R3 busy write ignored");
    wr(8'h34, 32'h5555);
    idle(BUSY + 1);
    rd(8'h34, 32'h5555, "R3 later write taken");
    // R12 control fields
    uwr(8'h00, 32'hFFFF_FF29);
    rd(8'h00, 32'hA9, "R12 ctrl fields");
    // R6 R7 R10 advance
    pulse(TPS);
    rd(8'h04, 1, "R6 advance");
    rd(8'h00, 32'hE9, "R7 tick flag");
    chk_irq(1'b1, "R10 tick irq");
    // R8 write 1 keeps, write 0 clears
    uwr(8'h00, 32'h69);
    rd(8'h00, 32'hE9, "R8 write 1 keeps");
    uwr(8'h00, 32'h29);
    rd(8'h00, 32'hA9, "R8 write 0 clears");
    chk_irq(1'b0, "R10 irq after clear");
    // R8 set wins over same-cycle clear
    pulse(TPS - 1);
    uwr(8'h00, 32'h29, 1'b1);
    rd(8'h00, 32'hE9, "R8 set wins");
    rd(8'h04, 2, "R6 second advance");
    uwr(8'h00, 32'h29);
    rd(8'h00, 32'hA9, "R8 clear after coincide");
    // R6 hold while stopped
    uwr(8'h00, 32'h00);
    pulse(TPS);
    rd(8'h04, 2, "R6 hold");
    // R9 alarm
    uwr(8'h08, 5);
    uwr(8'h00, 32'h0D);
    pulse(2 * TPS);
    rd(8'h00, 32'hCD, "R9 no alarm before match");
    pulse(TPS);
    rd(8'h04, 5, "R9 sec at alarm");
    rd(8'h00, 32'hDD, "R9 alarm flag");
    chk_irq(1'b1, "R10 alarm irq");
    uwr(8'h00, 32'h55);
    rd(8'h00, 32'hD5, "R10 masked flags");
    chk_irq(1'b0, "R10 masked irq");
    // R6 wrap
    uwr(8'h00, 32'h00);
    uwr(8'h04, 32'hFFFF_FFFF);
    uwr(8'h00, 32'h01);
    pulse(TPS);
    rd(8'h04, 0, "R6 wrap");
    idle(3);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule